// File: doc/BRIEF.md
# Vector Memory Read Setup Controller

This block turns read-setup commands into a stream of 32-bit words fetched from a local vector memory. A setup names a word count and a start address. The controller then reads the memory one word per cycle at increasing addresses and writes each word into an internal read FIFO. A processor pops words from the head of that FIFO.

Setups are not queued. A setup arriving while the active one still has two or more words left to move is dropped without any indication. A setup is accepted if the controller is idle. It is also accepted if exactly one word is left and that word moves into the FIFO in the same cycle. A pop against an empty FIFO raises a stall and consumes nothing, so the reader never sees undefined data. A status output reports how many words of the active setup are still to be transferred.

The memory port has zero latency: the read data must be valid in the same cycle as the request and address.

Top module: `vrd_setup_ctrl`

## Requirements
- R1: After reset the remaining count is 0, no memory request is made and the FIFO is empty.
- R2: In the cycle after a setup is accepted, the memory request is high at the setup's start address. From then on, one word per cycle moves from the memory into the FIFO, at addresses rising by one and wrapping from the top address to 0.
- R3: A setup presented while two or more words of the active setup are still to be transferred is ignored. The remaining count and address of the active setup carry on unchanged, and none of the dropped setup's words are ever delivered.
- R4: A setup presented while exactly one word remains, and that word moves into the FIFO in the same cycle, is accepted. The single word is kept and is followed by all words of the new setup.
- R5: While a pop is requested and the FIFO is empty, the stall output is high and nothing is consumed. The stall drops in the first cycle a word is present, and the pop then returns that word.
- R6: The FIFO holds 16 words. While it is full, no memory request is made, and the remaining count and address hold.
- R7: The remaining-count output equals the number of words of the active setup not yet written into the FIFO. It is loaded with the setup count in the cycle after acceptance and falls by one per transfer.
- R8: Words leave the FIFO in the order they entered. A pop without a stall removes the head word shown on the data output in that cycle.
- R9: An accepted setup with a count of 0 makes no memory request and leaves the remaining count at 0.
- R10: A setup presented while exactly one word remains but the FIFO is full is ignored. That word stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_valid_i | input | 1 | Setup command strobe |
| setup_count_i | input | CNT_W | Number of words requested |
| setup_addr_i | input | ADDR_W | First word address |
| mem_req_o | output | 1 | Memory read request; one word moves this cycle |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the same cycle as the request |
| pop_i | input | 1 | Reader pop request |
| pop_data_o | output | DATA_W | Word at the FIFO head |
| pop_stall_o | output | 1 | Pop requested while the FIFO is empty |
| remaining_o | output | CNT_W | Words of the active setup still to be transferred |

## Verification
The bench uses the default parameters: a 16-entry FIFO, a 6-bit count and an 8-bit address. With these values, a 20-word setup fills the FIFO while four words are still pending, so the pause on a full FIFO and a setup rejected during that pause can both be seen. A 17-word setup leaves exactly one word blocked behind a full FIFO. A start address near 255 exposes the address wrap. The bench's memory model returns each address inside a fixed tag, so every popped word shows which address it came from.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/vrd_fifo.sv
module vrd_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = vrd_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W:0] LVL_MAX = (PTR_W+1)'(DEPTH);
  localparam logic [PTR_W:0] LVL_ONE = (PTR_W+1)'(1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [PTR_W:0]    lvl_q;
  logic              do_pop;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LVL_MAX);
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = slot_q[rd_ptr_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     slot_q[g] <= '0;
      else if (push_i && wr_ptr_q == PTR_W'(g))        slot_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop) rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, do_pop})
        2'b10:   lvl_q <= lvl_q + LVL_ONE;
        2'b01:   lvl_q <= lvl_q - LVL_ONE;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R8
  level_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !do_pop) |=> lvl_q == $past(lvl_q) + LVL_ONE);
endmodule

// File: rtl/vrd_setup_seq.sv
module vrd_setup_seq #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_valid_i,
  input  logic [CNT_W-1:0]  setup_count_i,
  input  logic [ADDR_W-1:0] setup_addr_i,
  input  logic              fifo_full_i,
  output logic              xfer_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  remaining_o
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic              take;

  assign xfer_o      = (rem_q != '0) && !fifo_full_i;
  // accept only when idle or when the last word drains this cycle
  assign take        = setup_valid_i && ((rem_q == '0) || (rem_q == CNT_ONE && xfer_o));
  assign addr_o      = addr_q;
  assign remaining_o = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      addr_q <= '0;
    end else if (take) begin
      rem_q  <= setup_count_i;
      addr_q <= setup_addr_i;
    end else if (xfer_o) begin
      rem_q  <= rem_q - CNT_ONE;
      addr_q <= addr_q + ADDR_ONE;
    end
  end

  // R3
  drop_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_valid_i && rem_q > CNT_ONE && !fifo_full_i) |=> rem_q == $past(rem_q) - CNT_ONE);
  // R6
  hold_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q != '0 && fifo_full_i) |=> ($stable(rem_q) && $stable(addr_q)));
  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !setup_valid_i) |=> addr_q == $past(addr_q) + ADDR_ONE);
endmodule

// File: rtl/vrd_setup_ctrl.sv
module vrd_setup_ctrl #(
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DATA_W     = vrd_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_valid_i,
  input  logic [CNT_W-1:0]  setup_count_i,
  input  logic [ADDR_W-1:0] setup_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_stall_o,
  output logic [CNT_W-1:0]  remaining_o
);
  logic fifo_full, fifo_empty, xfer;

  vrd_setup_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .setup_valid_i (setup_valid_i),
    .setup_count_i (setup_count_i),
    .setup_addr_i  (setup_addr_i),
    .fifo_full_i   (fifo_full),
    .xfer_o        (xfer),
    .addr_o        (mem_addr_o),
    .remaining_o   (remaining_o)
  );

  vrd_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (xfer),
    .wdata_i (mem_rdata_i),
    .pop_i   (pop_i),
    .rdata_o (pop_data_o),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign mem_req_o   = xfer;
  assign pop_stall_o = pop_i && fifo_empty;

  // R5
  stall_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_stall_o && !mem_req_o) |=> fifo_empty);
  // R9
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remaining_o == '0) |-> !mem_req_o);
endmodule

// File: tb/vrd_setup_ctrl_bench.sv
module vrd_setup_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_valid = 1'b0;
  logic [5:0]  setup_count = '0;
  logic [7:0]  setup_addr = '0;
  logic        mem_req;
  logic [7:0]  mem_addr;
  logic [31:0] mem_rdata;
  logic        pop = 1'b0;
  logic [31:0] pop_data;
  logic        pop_stall;
  logic [5:0]  remaining;
  int          n_chk = 0;
  int          n_err = 0;

  always #5 clk = ~clk;

  assign mem_rdata = {24'hC35A00, mem_addr};

  vrd_setup_ctrl u_vrd_setup_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .setup_valid_i(setup_valid), .setup_count_i(setup_count), .setup_addr_i(setup_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .pop_i(pop), .pop_data_o(pop_data), .pop_stall_o(pop_stall),
    .remaining_o(remaining)
  );

  function automatic logic [31:0] word_of(input logic [7:0] a);
    return {24'hC35A00, a};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_setup(input logic [5:0] cnt, input logic [7:0] a);
    setup_valid = 1'b1; setup_count = cnt; setup_addr = a;
    @(negedge clk);
    setup_valid = 1'b0;
  endtask

  // pops one word, waiting through stalls
  task automatic pop_expect(input string req, input logic [7:0] a);
    int guard = 0;
    pop = 1'b1;
    #1;
    while (pop_stall && guard < 50) begin
      @(negedge clk); #1; guard++;
    end
    check(req, "pop word", pop_data, word_of(a));
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    pop = 1'b1; #1;
    check(req, "stall on empty", {31'b0, pop_stall}, 32'd1);
    pop = 1'b0; #1;
  endtask

  task automatic t_reset;
    check("R1", "remaining after reset", {26'b0, remaining}, 32'd0);
    check("R1", "mem_req after reset", {31'b0, mem_req}, 32'd0);
    expect_empty("R1");
  endtask

  task automatic t_basic;
    do_setup(6'd4, 8'h10);
    check("R7", "remaining loaded", {26'b0, remaining}, 32'd4);
    check("R2", "first req", {31'b0, mem_req}, 32'd1);
    check("R2", "first addr", {24'b0, mem_addr}, 32'h10);
    cyc(1);
    check("R7", "remaining after one", {26'b0, remaining}, 32'd3);
    check("R2", "second addr", {24'b0, mem_addr}, 32'h11);
    cyc(3);
    check("R7", "remaining drained", {26'b0, remaining}, 32'd0);
    for (int i = 0; i < 4; i++) pop_expect("R8", 8'h10 + 8'(i));
    expect_empty("R8");
  endtask

  task automatic t_drop;
    do_setup(6'd2, 8'h20);
    do_setup(6'd2, 8'h40);
    check("R3", "remaining after drop", {26'b0, remaining}, 32'd1);
    check("R3", "addr after drop", {24'b0, mem_addr}, 32'h21);
    cyc(3);
    pop_expect("R3", 8'h20);
    pop_expect("R3", 8'h21);
    expect_empty("R3");
  endtask

  task automatic t_chain;
    do_setup(6'd1, 8'h50);
    do_setup(6'd3, 8'h60);
    check("R4", "remaining after chain", {26'b0, remaining}, 32'd3);
    check("R4", "addr after chain", {24'b0, mem_addr}, 32'h60);
    cyc(4);
    pop_expect("R4", 8'h50);
    pop_expect("R4", 8'h60);
    pop_expect("R4", 8'h61);
    pop_expect("R4", 8'h62);
    expect_empty("R4");
  endtask

  task automatic t_stall;
    pop = 1'b1;
    setup_valid = 1'b1; setup_count = 6'd1; setup_addr = 8'h70;
    #1;
    check("R5", "stall before data", {31'b0, pop_stall}, 32'd1);
    @(negedge clk);
    setup_valid = 1'b0;
    #1;
    check("R5", "stall while word pending", {31'b0, pop_stall}, 32'd1);
    @(negedge clk); #1;
    check("R5", "stall drops with data", {31'b0, pop_stall}, 32'd0);
    check("R5", "data after stall", pop_data, word_of(8'h70));
    @(negedge clk); #1;
    check("R5", "stall again when empty", {31'b0, pop_stall}, 32'd1);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_full;
    do_setup(6'd20, 8'h80);
    cyc(16);
    check("R6", "remaining held at full", {26'b0, remaining}, 32'd4);
    check("R6", "no req at full", {31'b0, mem_req}, 32'd0);
    do_setup(6'd3, 8'hE0);
    check("R3", "setup dropped at full", {26'b0, remaining}, 32'd4);
    cyc(2);
    check("R6", "still held", {26'b0, remaining}, 32'd4);
    for (int i = 0; i < 20; i++) pop_expect("R6", 8'h80 + 8'(i));
    cyc(1);
    expect_empty("R6");
  endtask

  task automatic t_full_one;
    do_setup(6'd17, 8'h00);
    cyc(16);
    check("R10", "one pending at full", {26'b0, remaining}, 32'd1);
    do_setup(6'd2, 8'hA0);
    check("R10", "setup dropped, word kept", {26'b0, remaining}, 32'd1);
    check("R10", "addr kept", {24'b0, mem_addr}, 32'h10);
    for (int i = 0; i < 17; i++) pop_expect("R10", 8'(i));
    cyc(2);
    check("R10", "remaining zero", {26'b0, remaining}, 32'd0);
    expect_empty("R10");
  endtask

  task automatic t_zero;
    do_setup(6'd0, 8'h33);
    check("R9", "remaining zero count", {26'b0, remaining}, 32'd0);
    check("R9", "no req zero count", {31'b0, mem_req}, 32'd0);
    cyc(2);
    expect_empty("R9");
  endtask

  task automatic t_wrap;
    do_setup(6'd3, 8'hFE);
    cyc(3);
    pop_expect("R2", 8'hFE);
    pop_expect("R2", 8'hFF);
    pop_expect("R2", 8'h00);
    expect_empty("R2");
  endtask

  bit done = 1'b0;

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_basic();
    t_drop();
    t_chain();
    t_stall();
    t_full();
    t_full_one();
    t_zero();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule